// File: doc/BRIEF.md
# Pipelined Converter Digital Error Correction

This block is the digital back end of a four-stage pipelined analog-to-digital converter. Each clock it receives one raw sub-code from each of four flash quantizers. Those sub-codes resolve 5, 4, 3 and 3 raw bits. The first three stages each carry one redundant bit, and the last stage is a plain flash. The codes of one sample do not arrive together. The second and third codes arrive one clock after the first, and the fourth arrives two clocks after it. Per-stage skew lines delay each code so that all four codes of one sample meet in the same cycle.

The aligned codes are merged by overlap-and-add. Each code is placed so that its lowest bit overlaps the highest bit of the next stage's code. A comparator decision that lands one step off inside a stage is therefore repaired by the stage that follows. The sum is clamped to twelve bits and optionally converted to two's complement. It is then registered once. An output-enable gates the data bus, and a high-impedance bus is modelled as a drive flag plus `z` on the data lines. After reset, a two-state controller (PRIME, STREAM) holds the output at zero until the pipeline has been filled by three samples.

Top module: `adc_digital_corrector`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears every delay register and the output word. After that edge, `word_valid` is 0 and, with the bus enabled, `dout` reads 0x000. A reset asserted in the middle of a stream has the same effect.
- R2: After reset is released, the controller stays in PRIME for the first three rising edges, then moves to STREAM. During those three edges `word_valid` stays 0 and the enabled bus reads 0x000, whatever codes are applied. The word loaded on the fourth edge after release is the first with `word_valid` = 1.
- R3: Take a sample whose stage-1 code is captured at edge E. Its stage-2 and stage-3 codes are captured at E+1, and its stage-4 code at E+2. The corrected word for that sample appears on `dout` after edge E+3. A new sample is accepted on every edge.
- R4: The corrected value is c1·128 + c2·16 + c3·4 + c4, where c1..c4 are the raw stage codes read as unsigned numbers. Adjacent codes therefore overlap in one bit position.
- R5: Consider codes produced by quantizers with comparator offsets of less than half a decision step per stage. In straight-binary mode, the resulting word equals an ideal 12-bit quantizer's output, floor(4096·x) for an input fraction x in [0,1).
- R6: When the weighted sum exceeds 4095 (for example codes 31,7,3,4 giving 4096), the word saturates at 0xFFF and never wraps. Input above full scale yields 0xFFF.
- R7: All-zero codes and input below zero give 0x000. Midscale input gives 0x800 (codes 16,0,0,0). The word 0xFFF is reached exactly at the sum 4095 (codes 31,7,3,3).
- R8: With `twos_mode` = 1 at the edge that loads the output register, the stored word is the saturated straight-binary word with only bit 11 inverted.
- R9: `out_en` acts without a clock. When it is low, `bus_drive` is 0 and `dout` is high impedance. When it is high, `bus_drive` is 1 and `dout` shows the stored word. `out_en` has no effect on the pipeline contents.
- R10: Once `word_valid` is 1 it stays 1 until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Conversion clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| twos_mode | input | 1 | 1 selects two's-complement output (bit 11 inverted) |
| out_en | input | 1 | Data bus enable, active high |
| flash1_code | input | 5 | Raw code of stage 1, captured at the sample's first edge |
| flash2_code | input | 4 | Raw code of stage 2, captured one edge later |
| flash3_code | input | 3 | Raw code of stage 3, captured one edge later |
| flash4_code | input | 3 | Raw code of the final flash, captured two edges later |
| word_valid | output | 1 | High once the pipeline has filled after reset |
| bus_drive | output | 1 | High while the data bus is driven |
| dout | output | 12 | Corrected word, high impedance while `bus_drive` is 0 |

## Verification
The hardest case to reach from the ports is a stage-1 decision that lands one step away from the ideal one. The correction must then rely on the following stage's redundant range to recover the exact ideal code. The bench reaches this case by modelling the quantizer chain itself. It places input fractions one step either side of every stage-1 decision threshold and applies comparator offsets of three-eighths of a step in both directions, so the first code is pushed across its threshold while later stages absorb the error. The saturation boundary is hit just as deliberately, with raw code sets that sum to exactly 4095 and to 4096.

// File: rtl/adc_corr_pkg.sv
`timescale 1ns/1ps
package adc_corr_pkg;

    // Fill controller states
    typedef enum logic [0:0] {
        ST_PRIME  = 1'b0,   // pipeline filling, output held at zero
        ST_STREAM = 1'b1    // one corrected word loaded per clock
    } fill_state_e;

    function automatic int lag_max(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/corr_skew_line.sv
`timescale 1ns/1ps
module corr_skew_line #(
    parameter int W     = 4,
    parameter int DEPTH = 1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] tap [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) tap[i] <= '0;
        end else begin
            tap[0] <= din;
            for (int i = 1; i < DEPTH; i++) tap[i] <= tap[i-1];
        end
    end

    assign dout = tap[DEPTH-1];

endmodule

// File: rtl/corr_merge.sv
`timescale 1ns/1ps
module corr_merge #(
    parameter int R1 = 5,
    parameter int R2 = 4,
    parameter int R3 = 3,
    parameter int R4 = 3
) (
    input  logic [R1-1:0]          c1,
    input  logic [R2-1:0]          c2,
    input  logic [R3-1:0]          c3,
    input  logic [R4-1:0]          c4,
    input  logic                   twos,
    output logic [R1+R2+R3+R4-4:0] word
);

    // each stage's lowest bit overlaps the next stage's highest bit
    localparam int S4 = 0;
    localparam int S3 = S4 + R4 - 1;
    localparam int S2 = S3 + R3 - 1;
    localparam int S1 = S2 + R2 - 1;
    localparam int OW = S1 + R1;
    localparam int SW = OW + 2;
    localparam logic [SW-1:0] TOP = SW'((1 << OW) - 1);

    logic [SW-1:0] sum;
    logic [OW-1:0] clipped;

    always_comb begin
        sum = (SW'(c1) << S1) + (SW'(c2) << S2) + (SW'(c3) << S3) + (SW'(c4) << S4);
        if (sum > TOP) clipped = '1;
        else           clipped = sum[OW-1:0];
        word = clipped ^ {twos, {(OW-1){1'b0}}};
    end

endmodule

// File: rtl/corr_fill_ctrl.sv
`timescale 1ns/1ps
module corr_fill_ctrl
    import adc_corr_pkg::*;
#(
    parameter int FILL_N = 3
) (
    input  logic clk,
    input  logic rst,
    output logic load_en
);

    localparam int CW = $clog2(FILL_N + 1);

    fill_state_e state, state_nxt;
    logic [CW-1:0] cnt, cnt_nxt;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_PRIME;
            cnt   <= '0;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
        end
    end

    // transitions: PRIME -> STREAM after FILL_N edges, STREAM holds
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        unique case (state)
            ST_PRIME: begin
                if (cnt == CW'(FILL_N - 1)) state_nxt = ST_STREAM;
                else                        cnt_nxt   = cnt + 1'b1;
            end
            ST_STREAM: state_nxt = ST_STREAM;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state)
            ST_PRIME:  load_en = 1'b0;
            ST_STREAM: load_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/adc_digital_corrector.sv
`timescale 1ns/1ps
module adc_digital_corrector
    import adc_corr_pkg::*;
#(
    parameter int RAW1 = 5,
    parameter int RAW2 = 4,
    parameter int RAW3 = 3,
    parameter int RAW4 = 3,
    parameter int LAG1 = 0,
    parameter int LAG2 = 1,
    parameter int LAG3 = 1,
    parameter int LAG4 = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         twos_mode,
    input  logic                         out_en,
    input  logic [RAW1-1:0]              flash1_code,
    input  logic [RAW2-1:0]              flash2_code,
    input  logic [RAW3-1:0]              flash3_code,
    input  logic [RAW4-1:0]              flash4_code,
    output logic                         word_valid,
    output logic                         bus_drive,
    output logic [RAW1+RAW2+RAW3+RAW4-4:0] dout
);

    localparam int OUT_W  = RAW1 + RAW2 + RAW3 + RAW4 - 3;
    localparam int MAXLAG = lag_max(LAG1, LAG2, LAG3, LAG4);
    localparam int DEP1   = MAXLAG - LAG1 + 1;
    localparam int DEP2   = MAXLAG - LAG2 + 1;
    localparam int DEP3   = MAXLAG - LAG3 + 1;
    localparam int DEP4   = MAXLAG - LAG4 + 1;

    logic [RAW1-1:0]  al1;
    logic [RAW2-1:0]  al2;
    logic [RAW3-1:0]  al3;
    logic [RAW4-1:0]  al4;
    logic [OUT_W-1:0] merged;
    logic [OUT_W-1:0] word_q;
    logic             valid_q;
    logic             load_en;

    corr_skew_line #(.W(RAW1), .DEPTH(DEP1)) u_skew1 (.clk(clk), .rst(rst), .din(flash1_code), .dout(al1));
    corr_skew_line #(.W(RAW2), .DEPTH(DEP2)) u_skew2 (.clk(clk), .rst(rst), .din(flash2_code), .dout(al2));
    corr_skew_line #(.W(RAW3), .DEPTH(DEP3)) u_skew3 (.clk(clk), .rst(rst), .din(flash3_code), .dout(al3));
    corr_skew_line #(.W(RAW4), .DEPTH(DEP4)) u_skew4 (.clk(clk), .rst(rst), .din(flash4_code), .dout(al4));

    corr_merge #(.R1(RAW1), .R2(RAW2), .R3(RAW3), .R4(RAW4)) u_merge (
        .c1(al1), .c2(al2), .c3(al3), .c4(al4), .twos(twos_mode), .word(merged)
    );

    corr_fill_ctrl #(.FILL_N(DEP1)) u_fill (.clk(clk), .rst(rst), .load_en(load_en));

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q  <= '0;
            valid_q <= 1'b0;
        end else if (load_en) begin
            word_q  <= merged;
            valid_q <= 1'b1;
        end
    end

    assign word_valid = valid_q;
    assign bus_drive  = out_en;
    assign dout       = out_en ? word_q : 'z;

endmodule

// File: rtl/corr_chk.sv
`timescale 1ns/1ps
module corr_chk #(
    parameter int OW  = 12,
    parameter int W1  = 5,
    parameter int W2  = 4,
    parameter int LAT = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          out_en,
    input logic          twos_mode,
    input logic [W1-1:0] flash1_code,
    input logic [W2-1:0] flash2_code,
    input logic          word_valid,
    input logic [OW-1:0] dout
);

    localparam int CW = $clog2(LAT + 2);

    logic [CW-1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)                           since_rst <= '0;
        else if (since_rst != CW'(LAT + 1)) since_rst <= since_rst + 1'b1;
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (!word_valid && (!out_en || dout == '0)));

    // R2
    fill_length_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid == (since_rst == CW'(LAT + 1)));

    // R2
    fill_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (!word_valid && out_en) |-> dout == '0);

    // R10
    valid_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        word_valid |=> word_valid);

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(flash1_code, LAT + 1) == '1 && $past(flash2_code, LAT) >= W2'(8)
         && !$past(twos_mode) && word_valid && out_en) |-> dout == '1);

endmodule

bind adc_digital_corrector corr_chk u_chk (
    .clk(clk), .rst(rst), .out_en(out_en), .twos_mode(twos_mode),
    .flash1_code(flash1_code), .flash2_code(flash2_code),
    .word_valid(word_valid), .dout(dout)
);

// File: tb/adc_digital_corrector_tb.sv
`timescale 1ns/1ps
module adc_digital_corrector_tb;

    localparam int D   = 16384;   // analog fraction denominator
    localparam int OFS = 6144;    // 3/8 of a decision step

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        twos_mode = 1'b0;
    logic        out_en = 1'b1;
    logic [4:0]  f1 = '0;
    logic [3:0]  f2 = '0;
    logic [2:0]  f3 = '0;
    logic [2:0]  f4 = '0;
    logic        word_valid;
    logic        bus_drive;
    logic [11:0] dout;

    int nchk = 0;
    int nfail = 0;
    int a1 [256];
    int a2 [256];
    int a3 [256];
    int a4 [256];
    int ex [256];

    always #2.5 clk = ~clk;

    adc_digital_corrector u_dut (
        .clk(clk), .rst(rst), .twos_mode(twos_mode), .out_en(out_en),
        .flash1_code(f1), .flash2_code(f2), .flash3_code(f3), .flash4_code(f4),
        .word_valid(word_valid), .bus_drive(bus_drive), .dout(dout)
    );

    task automatic check(input string tag, input int act, input int expv);
        nchk++;
        if (act != expv) begin
            nfail++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int raw_expect(int c1, int c2, int c3, int c4, bit tw);
        int s;
        s = c1 * 128 + c2 * 16 + c3 * 4 + c4;
        if (s > 4095) s = 4095;
        if (tw) s = s ^ 2048;
        return s;
    endfunction

    function automatic int ideal_code(int x);
        if (x < 0) return 0;
        if ((x >>> 2) > 4095) return 4095;
        return x >>> 2;
    endfunction

    function automatic int decide(int g, int y, int e);
        int num;
        int c;
        num = 2 * g * y - D / 2 + e;
        c = (num < 0) ? 0 : num / D;
        if (c > 2 * g - 2) c = 2 * g - 2;
        return c;
    endfunction

    // quantizer chain model with comparator offsets e1..e3
    task automatic put_analog(input int k, input int x, input int e1, input int e2, input int e3);
        int y;
        int c;
        y = x;
        c = decide(16, y, e1); a1[k] = c; y = 16 * y - c * (D / 2);
        c = decide(8, y, e2);  a2[k] = c; y = 8 * y - c * (D / 2);
        c = decide(4, y, e3);  a3[k] = c; y = 4 * y - c * (D / 2);
        c = (y < 0) ? 0 : (8 * y) / D;
        if (c > 7) c = 7;
        a4[k] = c;
        ex[k] = ideal_code(x);
    endtask

    task automatic put_raw(input int k, input int c1, input int c2, input int c3, input int c4, input bit tw);
        a1[k] = c1; a2[k] = c2; a3[k] = c3; a4[k] = c4;
        ex[k] = raw_expect(c1, c2, c3, c4, tw);
    endtask

    // staggered delivery: stage1 at t, stages 2/3 at t+1, stage 4 at t+2 (R3)
    task automatic play(input int n, input string tag);
        for (int t = 0; t < n + 3; t++) begin
            @(negedge clk);
            f1 = (t < n) ? 5'(a1[t]) : '0;
            f2 = (t >= 1 && t - 1 < n) ? 4'(a2[t-1]) : '0;
            f3 = (t >= 1 && t - 1 < n) ? 3'(a3[t-1]) : '0;
            f4 = (t >= 2 && t - 2 < n) ? 3'(a4[t-2]) : '0;
            @(posedge clk); #1;
            if (t >= 3) check(tag, int'(dout), ex[t-3]);
        end
    endtask

    task automatic t_reset_fill();
        @(negedge clk);
        rst = 1'b1; out_en = 1'b1; twos_mode = 1'b0;
        f1 = 5'd31; f2 = 4'd15; f3 = 3'd7; f4 = 3'd7;
        repeat (2) @(posedge clk);
        #1;
        check("R1 valid in reset", int'(word_valid), 0);
        check("R1 word in reset", int'(dout), 0);
        @(negedge clk);
        rst = 1'b0;
        for (int e = 0; e < 4; e++) begin
            @(posedge clk); #1;
            if (e < 3) begin
                check("R2 valid while priming", int'(word_valid), 0);
                check("R2 word held zero", int'(dout), 0);
            end else begin
                check("R2 first valid", int'(word_valid), 1);
                check("R3 R6 first word saturated", int'(dout), 4095);
            end
        end
        for (int e = 0; e < 3; e++) begin
            @(posedge clk); #1;
            check("R10 valid stays", int'(word_valid), 1);
        end
    endtask

    task automatic t_weights();
        twos_mode = 1'b0;
        put_raw(0, 1, 0, 0, 0, 0);
        put_raw(1, 0, 1, 0, 0, 0);
        put_raw(2, 0, 0, 1, 0, 0);
        put_raw(3, 0, 0, 0, 5, 0);
        put_raw(4, 3, 8, 0, 0, 0);
        put_raw(5, 4, 0, 0, 0, 0);
        put_raw(6, 15, 15, 7, 7, 0);
        put_raw(7, 0, 0, 0, 0, 0);
        put_raw(8, 16, 0, 0, 0, 0);
        put_raw(9, 30, 14, 6, 7, 0);
        play(10, "R4 R7 weights");
    endtask

    task automatic t_saturate();
        twos_mode = 1'b0;
        put_raw(0, 31, 7, 3, 3, 0);
        put_raw(1, 31, 7, 3, 4, 0);
        put_raw(2, 31, 15, 7, 7, 0);
        put_raw(3, 31, 0, 0, 0, 0);
        put_raw(4, 30, 15, 0, 0, 0);
        put_raw(5, 31, 9, 0, 0, 0);
        play(6, "R6 saturation");
    endtask

    task automatic t_ideal_sweep();
        twos_mode = 1'b0;
        for (int k = 0; k < 200; k++)
            put_analog(k, (k * 2731 + 17) % D, ((k % 3) - 1) * OFS,
                       (((k + 1) % 3) - 1) * OFS, (((k + 2) % 3) - 1) * OFS);
        play(200, "R5 sweep with offsets");
    endtask

    task automatic t_threshold();
        twos_mode = 1'b0;
        for (int m = 0; m < 30; m++)
            for (int j = 0; j < 3; j++)
                put_analog(m * 3 + j, (2 * m + 1) * 256 + j - 1,
                           (j == 1) ? OFS : -OFS, (m % 2 == 0) ? OFS : -OFS, 0);
        play(90, "R5 stage1 threshold");
    endtask

    task automatic t_range();
        twos_mode = 1'b0;
        put_analog(0, 0, 0, 0, 0);
        put_analog(1, 8192, 0, 0, 0);
        put_analog(2, 16383, 0, 0, 0);
        put_analog(3, 16384, OFS, OFS, OFS);
        put_analog(4, 20000, -OFS, 0, OFS);
        put_analog(5, -1, 0, 0, 0);
        put_analog(6, -5000, OFS, OFS, OFS);
        put_analog(7, 3, -OFS, -OFS, -OFS);
        play(8, "R6 R7 range ends");
    endtask

    task automatic t_twos();
        @(negedge clk);
        twos_mode = 1'b1;
        put_raw(0, 16, 0, 0, 0, 1);
        put_raw(1, 0, 0, 0, 0, 1);
        put_raw(2, 31, 15, 7, 7, 1);
        put_raw(3, 5, 3, 2, 1, 1);
        put_raw(4, 20, 9, 4, 6, 1);
        play(5, "R8 twos complement");
        @(negedge clk);
        twos_mode = 1'b0;
    endtask

    task automatic t_oe();
        @(negedge clk);
        out_en = 1'b0; twos_mode = 1'b0;
        f1 = 5'd16; f2 = '0; f3 = '0; f4 = '0;
        for (int e = 0; e < 4; e++) begin
            @(posedge clk); #1;
            check("R9 bus released", int'(bus_drive), 0);
        end
        out_en = 1'b1;
        #1;
        check("R9 bus driven", int'(bus_drive), 1);
        check("R9 word kept while released", int'(dout), 2048);
    endtask

    task automatic t_midreset();
        @(negedge clk);
        f1 = 5'd20; f2 = 4'd3; f3 = 3'd2; f4 = 3'd1;
        rst = 1'b1;
        @(posedge clk); #1;
        check("R1 mid-run reset valid", int'(word_valid), 0);
        check("R1 mid-run reset word", int'(dout), 0);
        @(negedge clk);
        rst = 1'b0;
        repeat (4) @(posedge clk);
        #1;
        check("R1 refill valid", int'(word_valid), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nfail++;
        $display("FAIL R3 watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        t_reset_fill();
        t_weights();
        t_saturate();
        t_ideal_sweep();
        t_threshold();
        t_range();
        t_twos();
        t_oe();
        t_midreset();
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule